// File: doc/BRIEF.md
# Stereo PCM to I2S serializer

The block turns pairs of signed 16-bit stereo samples into a serial audio stream for a DAC. It counts ticks of a master-rate clock enable, which comes from an external audio master clock running at 384 times the sample rate. From these ticks it builds a bit clock eight ticks long and a word-select clock. Each sample is widened into a 24-bit slot that keeps its sign. The slot is shifted out MSB first, left channel then right channel, so one frame lasts 48 bit clocks.

A format input selects one of two framings. In standard I2S framing the word-select edge comes one bit clock before each channel's MSB. In left-justified framing the word-select edge and the MSB arrive together. A one-pair holding register, a 48-bit shift register, is loaded once per frame through a valid/ready handshake. If no pair is offered at that moment, the frame carries silence and an underrun pulse is raised.

Top module: `pcm_serial_tx`

## Requirements
- R1: A sample s goes out as the 24-bit word {s, 8'h00}. The sample's sign bit becomes bit 23 and the low eight bits are zero.
- R2: Each frame is 48 bit-clock periods. Slots 0..23 carry the left word and slots 24..47 the right word, each MSB first. Slot 0 is the left MSB.
- R3: The serial data and the word-select output change only at a bit-clock falling edge. Both stay constant while the bit clock is high, so a receiver can sample on the rising edge.
- R4: With fmt_lj = 0 (I2S), word-select is high in slots 23..46 and low in slots 47 and 0..22. It therefore changes one period before each MSB.
- R5: With fmt_lj = 1 (left-justified), word-select is low in slots 0..23 and high in slots 24..47. It changes together with each MSB.
- R6: The bit clock lasts DIV = 8 master ticks per period and is high for 4 of them. With one tick every two clocks, that is 16 clocks per period with 8 clocks high.
- R7: in_ready is high for one clock per frame, at the falling edge that drives slot 0, so frame starts are 768 clocks apart at the R6 rate. Both channels of the accepted pair are latched in that one transfer.
- R8: If in_valid is low while in_ready is high, the frame sends 48 zero bits and underrun is high for exactly one clock, in the cycle after the ready cycle.
- R9: While en is low (and after reset), bclk, lrclk, sdata, in_ready and underrun are low. After en rises, the first bit driven is the left MSB of slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds all outputs idle |
| mclk_ce | input | 1 | One-clock pulse per master-clock tick |
| fmt_lj | input | 1 | 0 = I2S framing, 1 = left-justified framing |
| in_valid | input | 1 | A stereo pair is offered |
| in_ready | output | 1 | The offered pair is taken this clock |
| in_left | input | 16 | Left sample, signed |
| in_right | input | 16 | Right sample, signed |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Word select, low = left, high = right |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | One-clock pulse when a frame starts without a pair |

## Verification
The assertions assume that fmt_lj is held steady while en is high. They also assume that mclk_ce is a one-clock pulse, so a bit-clock rise always follows a master tick. The stimulus changes the format only while the block is disabled. It pulses mclk_ce every second clock and changes in_valid and the samples just after a clock edge. Frames are rebuilt from the data seen on bit-clock rising edges, starting at the first rise after enable. They are compared against pairs recorded at each handshake, with an all-zero entry for a frame that had no pair.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } fmt_e;
endpackage

// File: rtl/pcm_tx_bclk.sv
module pcm_tx_bclk #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mclk_ce,
    output logic bclk,
    output logic fall_ev
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    typedef struct packed {
        logic [CW-1:0] div;
        logic          bclk;
    } bclk_st_t;

    bclk_st_t st_d, st_q;
    logic     fall_d;

    always_comb begin
        st_d   = st_q;
        fall_d = 1'b0;
        if (!en) begin
            st_d.div  = CW'(DIV - 1);
            st_d.bclk = 1'b0;
        end else if (mclk_ce) begin
            if (st_q.div == CW'(DIV - 1)) begin
                st_d.div = '0;
                fall_d   = 1'b1;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
            st_d.bclk = (st_d.div >= CW'(HALF));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.div  <= CW'(DIV - 1);
            st_q.bclk <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk    = st_q.bclk;
    assign fall_ev = fall_d;

    AST_BCLK_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.bclk) |-> $past(mclk_ce && en)) else $error("bclk rose without tick"); // R6
endmodule

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  fmt_e                fmt,
    input  logic                fall_ev,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                lrclk,
    output logic                sdata,
    output logic                underrun
);
    localparam int FRAME = 2 * SLOT_W;
    localparam int SW    = $clog2(FRAME);
    localparam int PAD   = SLOT_W - SAMPLE_W;

    typedef struct packed {
        logic [SW-1:0]    slot;
        logic [FRAME-1:0] shreg;
        logic             lrclk;
        logic             sdata;
        logic             underrun;
    } frm_st_t;

    frm_st_t          st_d, st_q;
    logic [SLOT_W-1:0] left_w, right_w;
    logic [FRAME-1:0]  word;
    logic              ready_d;

    generate
        if (PAD == 0) begin : g_nopad
            assign left_w  = in_left;
            assign right_w = in_right;
        end else begin : g_pad
            assign left_w  = {in_left,  {PAD{1'b0}}};
            assign right_w = {in_right, {PAD{1'b0}}};
        end
    endgenerate

    always_comb begin
        st_d          = st_q;
        st_d.underrun = 1'b0;
        ready_d       = en && fall_ev && (st_q.slot == '0);
        word          = st_q.shreg;
        if (!en) begin
            st_d = '0;
        end else if (fall_ev) begin
            if (st_q.slot == '0) begin
                word          = in_valid ? {left_w, right_w} : '0;
                st_d.underrun = !in_valid;
            end
            st_d.sdata = word[FRAME-1];
            st_d.shreg = word << 1;
            if (fmt == FMT_LJ) begin
                st_d.lrclk = (st_q.slot >= SW'(SLOT_W));
            end else begin
                st_d.lrclk = (st_q.slot >= SW'(SLOT_W - 1)) &&
                             (st_q.slot <= SW'(FRAME - 2));
            end
            st_d.slot = (st_q.slot == SW'(FRAME - 1)) ? '0 : st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = ready_d;
    assign lrclk    = st_q.lrclk;
    assign sdata    = st_q.sdata;
    assign underrun = st_q.underrun;

    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(in_ready && !in_valid)) else $error("spurious underrun"); // R8
    AST_LEFT_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_ready) |-> !lrclk) else $error("slot 0 not on left"); // R4
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 24,
    parameter int DIV      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                mclk_ce,
    input  logic                fmt_lj,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                bclk,
    output logic                lrclk,
    output logic                sdata,
    output logic                underrun
);
    logic fall_ev;
    fmt_e fmt;

    assign fmt = fmt_lj ? FMT_LJ : FMT_I2S;

    pcm_tx_bclk #(.DIV(DIV)) u_bclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .mclk_ce (mclk_ce),
        .bclk    (bclk),
        .fall_ev (fall_ev)
    );

    pcm_tx_framer #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .fmt      (fmt),
        .fall_ev  (fall_ev),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_left  (in_left),
        .in_right (in_right),
        .lrclk    (lrclk),
        .sdata    (sdata),
        .underrun (underrun)
    );

    AST_SDATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> !bclk) else $error("sdata moved with bclk high"); // R3
    AST_LRCLK_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk) |-> !bclk) else $error("lrclk moved with bclk high"); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) |-> (!bclk && !lrclk && !sdata && !underrun)) else $error("not idle"); // R9
endmodule

// File: tb/tb_pcm_serial_tx.sv
`timescale 1ns/1ps
module tb_pcm_serial_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        mclk_ce = 1'b0;
    logic        fmt_lj = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_left = '0;
    logic [15:0] in_right = '0;
    logic        in_ready, bclk, lrclk, sdata, underrun;

    pcm_serial_tx dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mclk_ce(mclk_ce), .fmt_lj(fmt_lj),
        .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
        .bclk(bclk), .lrclk(lrclk), .sdata(sdata), .underrun(underrun)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            #1 mclk_ce = ~mclk_ce;
        end
    end

    int nchk = 0;
    int nfail = 0;
    logic [47:0] expq[$];

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_lr(input int k, input bit lj);
        if (lj) return (k >= 24);
        return (k >= 23) && (k <= 46);
    endfunction

    // monitor and scoreboard
    longint cyc = 0;
    longint last_rise = -1;
    longint last_ready = -1;
    int     k = 0;
    int     per_chk = 0;
    bit     ur_pend = 0;
    bit     lr_bad = 0;
    bit     hold_bad = 0;
    bit     prev_bclk = 0;
    bit     prev_sd = 0;
    bit     prev_lr = 0;
    bit     prev_en = 0;
    logic [47:0] bits = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (ur_pend || underrun)
                chk(underrun == ur_pend, "R8 underrun pulse", 48'(underrun), 48'(ur_pend));
            ur_pend = 0;
            if (prev_en && en && prev_bclk && bclk && (sdata != prev_sd || lrclk != prev_lr))
                hold_bad = 1;
            if (!en) begin
                expq.delete();
                k = 0;
                last_rise = -1;
                last_ready = -1;
                lr_bad = 0;
            end else begin
                if (in_ready) begin
                    if (last_ready >= 0)
                        chk(cyc - last_ready == 768, "R7 ready spacing", 48'(cyc - last_ready), 48'd768);
                    last_ready = cyc;
                    if (in_valid) expq.push_back({in_left, 8'h00, in_right, 8'h00});
                    else begin
                        expq.push_back('0);
                        ur_pend = 1;
                    end
                end
                if (prev_bclk && !bclk && per_chk < 12) begin
                    per_chk++;
                    chk(cyc - last_rise == 8, "R6 high time", 48'(cyc - last_rise), 48'd8);
                end
                if (bclk && !prev_bclk) begin
                    if (last_rise >= 0 && per_chk < 12) begin
                        per_chk++;
                        chk(cyc - last_rise == 16, "R6 period", 48'(cyc - last_rise), 48'd16);
                    end
                    last_rise = cyc;
                    bits = {bits[46:0], sdata};
                    if (lrclk != exp_lr(k, fmt_lj)) lr_bad = 1;
                    if (k == 47) begin
                        chk(lr_bad == 0, fmt_lj ? "R5 word select" : "R4 word select", 48'(lr_bad), 48'd0);
                        if (expq.size() == 0) chk(0, "R2 frame without entry", bits, 48'h0);
                        else begin
                            logic [47:0] e;
                            e = expq.pop_front();
                            chk(bits == e, "R1 R2 frame data", bits, e);
                        end
                        k = 0;
                        lr_bad = 0;
                    end else k++;
                end
            end
        end
        prev_bclk = bclk;
        prev_sd = sdata;
        prev_lr = lrclk;
        prev_en = en;
    end

    task automatic report();
        chk(hold_bad == 0, "R3 outputs held while bclk high", 48'(hold_bad), 48'd0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    task automatic send_pair(input logic [15:0] l, input logic [15:0] r);
        @(posedge clk);
        #1;
        in_valid = 1;
        in_left = l;
        in_right = r;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 0;
        in_left = 16'hDEAD;
        in_right = 16'hBEEF;
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!in_ready);
    endtask

    task automatic end_phase();
        do @(negedge clk); while (expq.size() != 0);
        @(posedge clk);
        #1 en = 0;
        repeat (4) @(negedge clk);
        chk({bclk, lrclk, sdata, in_ready, underrun} == 5'b0, "R9 idle after disable",
            48'({bclk, lrclk, sdata, in_ready, underrun}), 48'd0);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        chk({bclk, lrclk, sdata, in_ready, underrun} == 5'b0, "R9 reset state",
            48'({bclk, lrclk, sdata, in_ready, underrun}), 48'd0);
        @(posedge clk);
        #1 rst_n = 1;
        repeat (20) @(negedge clk);
        chk({bclk, lrclk, sdata, in_ready} == 4'b0, "R9 idle while disabled",
            48'({bclk, lrclk, sdata, in_ready}), 48'd0);
        // I2S framing
        @(posedge clk);
        #1 begin fmt_lj = 0; en = 1; end
        send_pair(16'h7FFF, 16'h8000);
        send_pair(16'hFFFF, 16'h0001);
        send_pair(16'h1234, 16'hABCD);
        wait_ready();
        send_pair(16'h5A5A, 16'hA5A5);
        end_phase();
        // left-justified framing
        @(posedge clk);
        #1 begin fmt_lj = 1; en = 1; end
        send_pair(16'h8000, 16'h7FFF);
        send_pair(16'h0F0F, 16'hF0F0);
        send_pair(16'h0000, 16'hFFFF);
        end_phase();
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 48'd0, 48'd1);
        report();
    end
endmodule